// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is one bank of general-purpose pins: four ports of eight pins each, controlled through a simple register bus with a one-cycle write strobe and a one-cycle read strobe. For each port, software can select whether a pin is driven by the GPIO logic or by an alternate function, and can set its output value and output enable. It can read the synchronized pad level, and it can manage a per-pin interrupt status, an interrupt enable and an interrupt type. Event detection is done by a companion block. That block pulses `evt_in` to set status bits and reads the type bits from `int_type_o`. The bank combines enabled status into a single `irq_o`.

Each writable register has a masked-write alias. In a masked write, the upper byte of the write data chooses which pins change, so one pin can be updated without a read-modify-write sequence. The bus has no back-pressure. A write takes effect at the clock edge that samples the strobe, and read data is registered and returned one edge after the read strobe.

Top module: `gpb_bank`

## Requirements
- R1: After reset, every stored register reads 0, `irq_o` is 0, and each pad follows the alternate-function output and enable.
- R2: The register of kind k for port p sits at byte address 16*k + 4*p. Kinds are 0 pin function, 1 drive enable, 2 drive value, 3 pad level, 4 event status, 5 event enable, 6 event type and 7 status clear. A plain write stores `bus_wdata[7:0]` and ignores the upper bits. A read returns the byte in bits 7:0, with bits 31:8 at 0.
- R3: The pad-level register returns `pad_in` after two synchronizer flops. A pad change made before edge E1 is first returned by a read strobed at edge E3; a read strobed at E2 still returns the old level.
- R4: Address + 0x800 is a masked alias for kinds 0, 1, 2, 4, 5 and 6. Bits 15:8 of the write data enable individual pins, bits 7:0 give their new values, and pins that are not enabled keep their stored value.
- R5: A pulse on `evt_in[n]` sets status bit n at the next edge. If a clear or status write of that bit happens in the same cycle, the set wins.
- R6: Writing the clear register (kind 7) clears the status bits that are 1 in `bus_wdata[7:0]`. Reading it returns 0.
- R7: `irq_o` is 1 exactly when some status bit and its enable bit are both 1.
- R8: When the function bit of a pin is 1, `pad_out` and `pad_oe` follow its drive value and drive enable. When it is 0, they follow `alt_out` and `alt_oe`.
- R9: An address is unmapped when bits 1:0 are not 0, when bits 10:7 are not 0, when it is a masked alias of kind 3 or 7, or when it falls anywhere in the alias range for a read. Unmapped reads return 0 and unmapped writes change nothing. Writes to the pad-level register are also ignored.
- R10: `bus_rdata` changes only at an edge where `bus_rd` is 1 and holds its value otherwise.
- R11: `int_type_o[8p+n]` shows the stored event-type bit n of port p.
- R12: `alt_in` is `pad_in` passed straight through, with no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | 12 | Byte address within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels, port p on bits 8p+7:8p |
| pad_out | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad output enable |
| alt_out | input | 32 | Alternate-function output value |
| alt_oe | input | 32 | Alternate-function output enable |
| alt_in | output | 32 | Unsynchronized pad input for the alternate function |
| evt_in | input | 32 | Per-pin event pulses from the detection block |
| int_type_o | output | 32 | Stored event-type bits |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A write changes a register at the edge that samples the strobe. The effect on `pad_out`, `pad_oe`, `int_type_o` and `irq_o` can be seen in the same cycle, so the bench samples those at the following falling edge. Read data is captured at the edge after the strobe and sampled at the falling edge after that. For a pad change, a read issued straight away is checked for the stale level and a read one cycle later for the new level, which pins down the two-flop delay. Event pulses are driven for one cycle and their status is read back after the pulse ends.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  typedef enum logic [2:0] {
    K_FUNC = 3'd0,
    K_OE   = 3'd1,
    K_OUT  = 3'd2,
    K_IN   = 3'd3,
    K_STA  = 3'd4,
    K_ENB  = 3'd5,
    K_TYPE = 3'd6,
    K_CLR  = 3'd7
  } reg_kind_e;

  localparam int ALIAS_BIT = 11;
  localparam int KIND_LSB  = 4;
  localparam int PORT_LSB  = 2;
endpackage

// File: rtl/gpb_decode.sv
module gpb_decode
  import gpb_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_PORTS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic              masked,
  output reg_kind_e         kind,
  output logic [1:0]        port
);
  logic base_hit;
  logic alias_ok;
  logic unused_hi;

  assign unused_hi = ^addr[ADDR_W-1:ALIAS_BIT+1];
  assign masked    = addr[ALIAS_BIT];
  assign kind      = reg_kind_e'(addr[KIND_LSB+2:KIND_LSB]);
  assign port      = addr[PORT_LSB+1:PORT_LSB];

  assign base_hit  = (addr[1:0] == 2'b00) &&
                     (addr[ALIAS_BIT-1:KIND_LSB+3] == '0) &&
                     (int'(port) < NUM_PORTS);
  assign alias_ok  = (kind != K_IN) && (kind != K_CLR);

  assign wr_ok = wr && base_hit && (kind != K_IN) && (!masked || alias_ok);
  assign rd_ok = rd && base_hit && !masked && (kind != K_CLR);
endmodule

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpb_port.sv
module gpb_port
  import gpb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          masked,
  input  reg_kind_e     kind,
  input  logic [2*W-1:0] wdata,
  input  logic [W-1:0]  evt,
  input  logic [W-1:0]  alt_out,
  input  logic [W-1:0]  alt_oe,
  output logic [W-1:0]  func_q,
  output logic [W-1:0]  oe_q,
  output logic [W-1:0]  out_q,
  output logic [W-1:0]  sta_q,
  output logic [W-1:0]  enb_q,
  output logic [W-1:0]  typ_q,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic          irq
);
  logic [W-1:0] upd_en;
  logic [W-1:0] upd_val;
  logic [W-1:0] sta_base;

  assign upd_en  = masked ? wdata[2*W-1:W] : '1;
  assign upd_val = wdata[W-1:0];

  function automatic logic [W-1:0] merge(input logic [W-1:0] old_v,
                                          input logic [W-1:0] en,
                                          input logic [W-1:0] val);
    return (old_v & ~en) | (val & en);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= '0;
      oe_q   <= '0;
      out_q  <= '0;
      enb_q  <= '0;
      typ_q  <= '0;
    end else if (wr_en) begin
      case (kind)
        K_FUNC:  func_q <= merge(func_q, upd_en, upd_val);
        K_OE:    oe_q   <= merge(oe_q, upd_en, upd_val);
        K_OUT:   out_q  <= merge(out_q, upd_en, upd_val);
        K_ENB:   enb_q  <= merge(enb_q, upd_en, upd_val);
        K_TYPE:  typ_q  <= merge(typ_q, upd_en, upd_val);
        default: ;
      endcase
    end
  end

  always_comb begin
    sta_base = sta_q;
    if (wr_en && kind == K_STA) sta_base = merge(sta_q, upd_en, upd_val);
    if (wr_en && kind == K_CLR) sta_base = sta_q & ~upd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sta_q <= '0;
    else        sta_q <= sta_base | evt;
  end

  assign pad_out = (func_q & out_q) | (~func_q & alt_out);
  assign pad_oe  = (func_q & oe_q)  | (~func_q & alt_oe);
  assign irq     = |(sta_q & enb_q);
endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
  import gpb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PINS      = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [NUM_PORTS*PINS-1:0]   pad_in,
  output logic [NUM_PORTS*PINS-1:0]   pad_out,
  output logic [NUM_PORTS*PINS-1:0]   pad_oe,
  input  logic [NUM_PORTS*PINS-1:0]   alt_out,
  input  logic [NUM_PORTS*PINS-1:0]   alt_oe,
  output logic [NUM_PORTS*PINS-1:0]   alt_in,
  input  logic [NUM_PORTS*PINS-1:0]   evt_in,
  output logic [NUM_PORTS*PINS-1:0]   int_type_o,
  output logic                        irq_o
);
  localparam int NPINS = NUM_PORTS * PINS;

  logic        wr_ok, rd_ok, masked;
  reg_kind_e   kind;
  logic [1:0]  port;
  logic [NPINS-1:0] in_sync;
  logic [NPINS-1:0] sta_all;
  logic [NUM_PORTS-1:0] port_irq;
  logic [PINS-1:0] func_w [NUM_PORTS];
  logic [PINS-1:0] oe_w   [NUM_PORTS];
  logic [PINS-1:0] out_w  [NUM_PORTS];
  logic [PINS-1:0] sta_w  [NUM_PORTS];
  logic [PINS-1:0] enb_w  [NUM_PORTS];
  logic [PINS-1:0] typ_w  [NUM_PORTS];
  logic [PINS-1:0] rd_byte;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:2*PINS];

  gpb_decode #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .masked(masked), .kind(kind), .port(port)
  );

  gpb_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    gpb_port #(.W(PINS)) u_port (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_ok && (int'(port) == p)),
      .masked(masked), .kind(kind),
      .wdata(bus_wdata[2*PINS-1:0]),
      .evt(evt_in[p*PINS +: PINS]),
      .alt_out(alt_out[p*PINS +: PINS]),
      .alt_oe(alt_oe[p*PINS +: PINS]),
      .func_q(func_w[p]), .oe_q(oe_w[p]), .out_q(out_w[p]),
      .sta_q(sta_w[p]), .enb_q(enb_w[p]), .typ_q(typ_w[p]),
      .pad_out(pad_out[p*PINS +: PINS]),
      .pad_oe(pad_oe[p*PINS +: PINS]),
      .irq(port_irq[p])
    );
    assign sta_all[p*PINS +: PINS]    = sta_w[p];
    assign int_type_o[p*PINS +: PINS] = typ_w[p];
  end

  always_comb begin
    case (kind)
      K_FUNC:  rd_byte = func_w[port];
      K_OE:    rd_byte = oe_w[port];
      K_OUT:   rd_byte = out_w[port];
      K_IN:    rd_byte = in_sync[port*PINS +: PINS];
      K_STA:   rd_byte = sta_w[port];
      K_ENB:   rd_byte = enb_w[port];
      K_TYPE:  rd_byte = typ_w[port];
      default: rd_byte = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_ok ? DATA_W'(rd_byte) : '0;
  end

  assign alt_in = pad_in;
  assign irq_o  = |port_irq;
endmodule

// File: rtl/gpb_bank_chk.sv
module gpb_bank_chk #(
  parameter int NUM_PORTS = 4,
  parameter int PINS      = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_wr,
  input logic                      bus_rd,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [DATA_W-1:0]         bus_wdata,
  input logic [DATA_W-1:0]         bus_rdata,
  input logic [NUM_PORTS*PINS-1:0] pad_in,
  input logic [NUM_PORTS*PINS-1:0] pad_out,
  input logic [NUM_PORTS*PINS-1:0] pad_oe,
  input logic [NUM_PORTS*PINS-1:0] alt_out,
  input logic [NUM_PORTS*PINS-1:0] alt_oe,
  input logic [NUM_PORTS*PINS-1:0] evt_in,
  input logic [NUM_PORTS*PINS-1:0] sta_all,
  input logic [NUM_PORTS*PINS-1:0] in_sync
);
  localparam int NPINS = NUM_PORTS * PINS;

  logic [1:0] cyc;
  logic clr_wr;
  logic rd_bad;
  logic [NPINS-1:0] clr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cyc <= '0;
    else if (cyc != 3) cyc <= cyc + 2'd1;
  end

  assign clr_wr = bus_wr && bus_addr[1:0] == 2'b00 && bus_addr[ADDR_W-1:7] == '0 &&
                  bus_addr[6:4] == 3'd7;
  assign clr_mask = clr_wr ? (NPINS'(bus_wdata[PINS-1:0]) << (int'(bus_addr[3:2]) * PINS)) : '0;
  assign rd_bad = bus_addr[1:0] != 2'b00 || bus_addr[10:7] != '0 || bus_addr[11] ||
                  bus_addr[6:4] == 3'd7;

  // R5: an event pulse leaves its status bit set
  a_r5_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_in) |=> ((sta_all & $past(evt_in)) == $past(evt_in)));

  // R6: clear register drops the named status bits unless a new event arrives
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((sta_all & $past(clr_mask & ~evt_in)) == '0));

  // R9: unmapped reads return zero
  a_r9_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && rd_bad) |=> (bus_rdata == '0));

  // R10: read data holds without a strobe
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 0 && !bus_rd) |=> $stable(bus_rdata));

  // R3: synchronized level trails the pad by two edges
  a_r3_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 3) |-> (in_sync == $past(pad_in, 2)));

  // R8: pads stay put when no write happened and the alternate inputs are steady
  a_r8_pad_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 0 && !$past(bus_wr) && $stable(alt_out) && $stable(alt_oe))
      |-> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpb_bank gpb_bank_chk #(
  .NUM_PORTS(NUM_PORTS), .PINS(PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .alt_out(alt_out), .alt_oe(alt_oe), .evt_in(evt_in),
  .sta_all(sta_all), .in_sync(in_sync)
);

// File: tb/gpb_bank_bench.sv
module gpb_bank_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0, pad_out, pad_oe, alt_out = '0, alt_oe = '0, alt_in;
  logic [31:0] evt_in = '0, int_type_o;
  logic        irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] m [4][8];
  logic [31:0] m_pad = '0;

  always #5 clk = ~clk;

  gpb_bank u_gpb_bank (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] ad(input int p, input int k, input bit msk);
    return (msk ? 12'h800 : 12'h000) | 12'(k << 4) | 12'(p << 2);
  endfunction

  function automatic logic [7:0] exp_rd(input int p, input int k);
    if (k == 3) return m_pad[p*8 +: 8];
    if (k == 7) return 8'h00;
    return m[p][k];
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 8; k++) begin
        rd(ad(p, k, 0), v);
        chk(tag, v, {24'h0, exp_rd(p, k)});
      end
  endtask

  function automatic logic [31:0] irq_exp();
    logic r = 0;
    for (int p = 0; p < 4; p++) r |= |(m[p][4] & m[p][5]);
    return {31'h0, r};
  endfunction

  task automatic check_pads(input string tag);
    logic [31:0] eo, ee;
    for (int p = 0; p < 4; p++) begin
      eo[p*8 +: 8] = (m[p][0] & m[p][2]) | (~m[p][0] & alt_out[p*8 +: 8]);
      ee[p*8 +: 8] = (m[p][0] & m[p][1]) | (~m[p][0] & alt_oe[p*8 +: 8]);
    end
    chk({tag, " out"}, pad_out, eo);
    chk({tag, " oe"}, pad_oe, ee);
  endtask

  initial begin
    logic [31:0] v, held;
    logic [7:0] en, val;
    for (int p = 0; p < 4; p++) for (int k = 0; k < 8; k++) m[p][k] = 8'h00;
    alt_out = 32'h1234_5678; alt_oe = 32'h0F0F_F0F0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    check_all("R1 reset regs");
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    check_pads("R1 pads");

    // R2: plain write sweep with junk in upper data bits
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 7; k++) if (k != 3) begin
        val = 8'((p * 37 + k * 11 + 1) * 13);
        wr(ad(p, k, 0), {16'hA5C3, 8'hFF, val});
        m[p][k] = val;
      end
    check_all("R2 plain rw");
    chk("R11 type out", int_type_o, {m[3][6], m[2][6], m[1][6], m[0][6]});
    chk("R7 irq plain", {31'h0, irq_o}, irq_exp());
    for (int a = 0; a < 4; a++) begin
      alt_out = 32'h9E37_79B9 * (a + 1); alt_oe = ~alt_out ^ (32'h3C << a);
      @(negedge clk);
      check_pads("R8 mux");
    end

    // R4: masked alias sweep
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 7; k++) if (k != 3)
        for (int s = 0; s < 5; s++) begin
          en  = (s == 0) ? 8'h00 : (s == 1) ? 8'hFF : (s == 2) ? 8'h0F : (s == 3) ? 8'h3C : 8'h81;
          val = ~m[p][k] ^ 8'(s * 5);
          wr(ad(p, k, 1), {16'h0, en, val});
          m[p][k] = (m[p][k] & ~en) | (val & en);
          rd(ad(p, k, 0), v);
          chk("R4 masked", v, {24'h0, m[p][k]});
        end
    chk("R11 type after mask", int_type_o, {m[3][6], m[2][6], m[1][6], m[0][6]});
    check_pads("R8 after mask");

    // R5/R6/R7: events, clear, interrupt
    for (int p = 0; p < 4; p++) begin
      wr(ad(p, 4, 1), 32'h0000_FF00); m[p][4] = 8'h00;
      wr(ad(p, 5, 0), 32'h0000_0000); m[p][5] = 8'h00;
    end
    chk("R7 irq idle", {31'h0, irq_o}, 32'h0);
    wr(ad(2, 5, 0), 32'h0000_0010); m[2][5] = 8'h10;
    @(negedge clk); evt_in = 32'h0001_0000;
    @(negedge clk); evt_in = '0; m[2][4] = 8'h01;
    chk("R7 irq not enabled", {31'h0, irq_o}, 32'h0);
    @(negedge clk); evt_in = 32'h0010_0000;
    @(negedge clk); evt_in = '0; m[2][4] = 8'h11;
    chk("R7 irq enabled", {31'h0, irq_o}, 32'h1);
    rd(ad(2, 4, 0), v); chk("R5 evt sets", v, 32'h11);
    wr(ad(2, 7, 0), 32'h0000_0010); m[2][4] = 8'h01;
    chk("R6 clear drops irq", {31'h0, irq_o}, 32'h0);
    rd(ad(2, 4, 0), v); chk("R6 clear", v, 32'h01);
    rd(ad(2, 7, 0), v); chk("R6 clear reads 0", v, 32'h0);
    // set wins over simultaneous clear
    @(negedge clk); bus_wr = 1; bus_addr = ad(2, 7, 0); bus_wdata = 32'hFF; evt_in = 32'h0080_0000;
    @(negedge clk); bus_wr = 0; evt_in = '0; m[2][4] = 8'h80;
    rd(ad(2, 4, 0), v); chk("R5 set beats clear", v, 32'h80);
    @(negedge clk); bus_wr = 1; bus_addr = ad(2, 4, 1); bus_wdata = 32'hFF00; evt_in = 32'h0002_0000;
    @(negedge clk); bus_wr = 0; evt_in = '0; m[2][4] = 8'h02;
    rd(ad(2, 4, 0), v); chk("R5 set beats status write", v, 32'h02);

    // R3/R12: pad input sync
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); pad_in = 32'hC6A4_A793 * (i + 3) + 32'(i);
      #1 chk("R12 alt_in", alt_in, pad_in);
      rd(ad(0, 3, 0), v); chk("R3 stale", v, {24'h0, m_pad[7:0]});
      m_pad = pad_in;
      rd(ad(0, 3, 0), v); chk("R3 new", v, {24'h0, m_pad[7:0]});
      for (int p = 1; p < 4; p++) begin
        rd(ad(p, 3, 0), v); chk("R3 port", v, {24'h0, m_pad[p*8 +: 8]});
      end
    end

    // R9: unmapped accesses
    wr(12'h001, 32'hFF); wr(12'h022, 32'hFF); wr(12'h080, 32'hFF); wr(12'h400, 32'hFF);
    wr(12'h830, 32'hFFFF); wr(12'h870, 32'hFFFF); wr(12'h834, 32'hFFFF); wr(12'h030, 32'hFF);
    wr(12'h8A0, 32'hFFFF);
    check_all("R9 writes ignored");
    rd(12'h800, v); chk("R9 alias read", v, 32'h0);
    rd(12'h841, v); chk("R9 alias misaligned", v, 32'h0);
    rd(12'h0A0, v); chk("R9 high bits", v, 32'h0);
    rd(12'h003, v); chk("R9 misaligned", v, 32'h0);

    // R10: hold of read data
    rd(ad(2, 4, 0), held);
    repeat (4) @(negedge clk);
    chk("R10 hold", bus_rdata, held);
    @(negedge clk); pad_in = ~pad_in;
    repeat (3) @(negedge clk);
    chk("R10 hold across pad change", bus_rdata, held);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule